// File: doc/BRIEF.md
# External Data Address Generator

This block forms the 16-bit address for an 8-bit microcontroller's external data reads and writes. It holds two 16-bit data pointers, a select register that picks which pointer is active, and a page register. There are two access modes. A paged access takes the high address byte from the page register and the low byte from a working register value supplied by the core. A pointer access uses the full 16 bits of the active pointer. Software can load or step only the active pointer. Switching the select bit leaves both pointers intact, so a copy loop can keep a source pointer and a destination pointer live at once.

The formed address is decoded into three physical regions. The first is 4 KB of shared volatile RAM. The second is a 256-byte window of configuration registers. The third is an 8-byte battery-backed hole carved out of the middle of that window. Everything else is empty address space. An access to empty space raises an unmapped flag, reads back zero and produces no write strobe. The instruction decoder, the RAM arrays and interrupt context saving sit outside this block.

Top module: `xdata_addr_gen`

## Requirements
- R1: While `acc_valid` and `acc_paged` are high, `xaddr` equals {page register, `ri_val`}, giving 256 pages of 256 bytes.
- R2: While `acc_valid` is high and `acc_paged` is low, `xaddr` equals the active data pointer.
- R3: A write to the select register stores only bit 0 of `sel_wr_data`. Value 0 makes pointer 0 active and value 1 makes pointer 1 active. Bits 7..1 have no effect.
- R4: Writing the select register changes neither pointer. Load and increment act only on the active pointer, and the inactive pointer keeps its value.
- R5: When `acc_valid` is high, exactly one of `sel_xram`, `sel_cfg`, `sel_bbram` or `unmapped` is high. The address ranges are: 0x0000–0x0FFF gives `sel_xram`; 0x2000–0x20BF and 0x20C8–0x20FF give `sel_cfg`; 0x20C0–0x20C7 gives `sel_bbram`; all other addresses give `unmapped`. When `acc_valid` is low, all four are low.
- R6: `mem_we` is high only for a mapped write (`acc_write`=1), and `mem_re` is high only for a mapped read (`acc_write`=0). `rd_data` passes `mem_rdata` only for a mapped read and is 0x00 otherwise, so an unmapped read returns 0x00 and an unmapped write has no effect.
- R7: The `ptr_op` encoding is 2'b00 hold, 2'b01 load all 16 bits from `ptr_load_val`, 2'b10 increment by one, and 2'b11 hold. The increment wraps 0xFFFF to 0x0000. The result is visible after the next rising clock edge.
- R8: In the cycle of a pointer op, a select write or a page write, `xaddr` still reflects the pointer, select and page values from before that edge.
- R9: A synchronous reset (`rst` high at a rising edge) clears both pointers, the select bit and the page register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_wr_en | input | 1 | Write strobe for the pointer-select register |
| sel_wr_data | input | 8 | Select register write value (bit 0 used) |
| page_wr_en | input | 1 | Write strobe for the page register |
| page_wr_data | input | 8 | Page register write value |
| ptr_op | input | 2 | Operation on the active pointer |
| ptr_load_val | input | 16 | Value for a pointer load |
| acc_valid | input | 1 | An external data access is in progress |
| acc_paged | input | 1 | 1 = paged access, 0 = pointer access |
| acc_write | input | 1 | 1 = write, 0 = read |
| ri_val | input | 8 | Low address byte for paged access |
| mem_rdata | input | 8 | Read data returned by the selected region |
| xaddr | output | 16 | Formed external data address |
| sel_xram | output | 1 | Shared RAM region selected |
| sel_cfg | output | 1 | Configuration register region selected |
| sel_bbram | output | 1 | Battery-backed region selected |
| unmapped | output | 1 | Access falls in empty address space |
| mem_we | output | 1 | Write strobe to a mapped region |
| mem_re | output | 1 | Read strobe to a mapped region |
| rd_data | output | 8 | Read data to the core |

## Verification
Two things can happen in the same cycle: a pointer access through the active pointer, and an increment or select change that retargets that same pointer. This is what happens when a copy loop reads through a pointer and steps it in one instruction. The bench applies a pointer access together with an increment, and separately together with a select write. It checks that `xaddr` shows the pre-edge pointer before the clock edge and the updated or newly selected pointer after it. The same before-and-after judgement covers page writes that land during a paged access.

// File: rtl/xag_pkg.sv
package xag_pkg;

  typedef enum logic [1:0] {
    PTR_HOLD = 2'b00,
    PTR_LOAD = 2'b01,
    PTR_INC  = 2'b10,
    PTR_RSVD = 2'b11
  } ptr_op_e;

  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_XRAM  = 2'd1,
    RGN_CFG   = 2'd2,
    RGN_BBRAM = 2'd3
  } region_e;

endpackage

// File: rtl/xag_ptr_bank.sv
module xag_ptr_bank
  import xag_pkg::*;
#(
  parameter int NUM_PTR  = 2,
  parameter int PTR_W    = 16,
  parameter int SELREG_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_wr_en,
  input  logic [SELREG_W-1:0] sel_wr_data,
  input  ptr_op_e             op,
  input  logic [PTR_W-1:0]    load_val,
  output logic [PTR_W-1:0]    cur_ptr
);

  localparam int SEL_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;

  // next value of the pointer that the op targets
  function automatic logic [PTR_W-1:0] ptr_next(input ptr_op_e o,
                                                input logic [PTR_W-1:0] cur,
                                                input logic [PTR_W-1:0] ld);
    case (o)
      PTR_LOAD: ptr_next = ld;
      PTR_INC:  ptr_next = cur + {{(PTR_W-1){1'b0}}, 1'b1};
      default:  ptr_next = cur;
    endcase
  endfunction

  logic [SEL_W-1:0] sel_q;
  logic [PTR_W-1:0] ptr_q [NUM_PTR];
  logic [NUM_PTR-1:0] ptr_hit;     // pointer g is the active one
  logic ptr_step;                  // increment event
  logic ptr_load;                  // load event

  assign ptr_step = (op == PTR_INC);
  assign ptr_load = (op == PTR_LOAD);

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (sel_wr_en) sel_q <= sel_wr_data[SEL_W-1:0];
  end

  generate
    if (SELREG_W > SEL_W) begin : g_sel_unused
      logic unused_sel_bits;
      assign unused_sel_bits = ^sel_wr_data[SELREG_W-1:SEL_W];
    end

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
      localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
      assign ptr_hit[g] = (sel_q == IDX);

      always_ff @(posedge clk) begin
        if (rst) ptr_q[g] <= '0;
        else if (ptr_hit[g]) ptr_q[g] <= ptr_next(op, ptr_q[g], load_val);
      end

      // R4: an inactive pointer never moves
      p_hold_other_r4: assert property (@(posedge clk) disable iff (rst)
        !ptr_hit[g] |=> $stable(ptr_q[g]))
        else $error("inactive pointer %0d changed", g);

      // R9: reset clears each pointer
      p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (ptr_q[g] == '0) && (sel_q == '0))
        else $error("pointer %0d not cleared by reset", g);
    end
  endgenerate

  assign cur_ptr = ptr_q[sel_q];

  // R7: increment steps the active pointer by one, wrapping
  p_inc_step_r7: assert property (@(posedge clk) disable iff (rst)
    (ptr_step && !sel_wr_en) |=> cur_ptr == $past(cur_ptr) + 1'b1)
    else $error("increment did not step active pointer");

  // R7: load writes all bits in one cycle
  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    (ptr_load && !sel_wr_en) |=> cur_ptr == $past(load_val))
    else $error("load did not take full value");

endmodule

// File: rtl/xag_addr_mux.sv
module xag_addr_mux #(
  parameter int PAGE_W = 8,
  parameter int LOW_W  = 8,
  localparam int ADDR_W = PAGE_W + LOW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              page_wr_en,
  input  logic [PAGE_W-1:0] page_wr_data,
  input  logic              acc_paged,
  input  logic [LOW_W-1:0]  ri_val,
  input  logic [ADDR_W-1:0] cur_ptr,
  output logic [ADDR_W-1:0] xaddr
);

  logic [PAGE_W-1:0] page_q;

  function automatic logic [ADDR_W-1:0] form_addr(input logic paged,
                                                  input logic [PAGE_W-1:0] pg,
                                                  input logic [LOW_W-1:0] lo,
                                                  input logic [ADDR_W-1:0] ptr);
    form_addr = paged ? {pg, lo} : ptr;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) page_q <= '0;
    else if (page_wr_en) page_q <= page_wr_data;
  end

  assign xaddr = form_addr(acc_paged, page_q, ri_val, cur_ptr);

  // R9: reset clears the page register
  p_page_reset_r9: assert property (@(posedge clk)
    rst |=> page_q == '0)
    else $error("page not cleared by reset");

  // R8: a page write lands only after the edge
  p_page_late_r8: assert property (@(posedge clk) disable iff (rst)
    (page_wr_en && acc_paged) |-> xaddr[ADDR_W-1:LOW_W] == page_q)
    else $error("page write leaked into current cycle");

endmodule

// File: rtl/xag_region_decode.sv
module xag_region_decode
  import xag_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] XRAM_LO = 16'h0000,
  parameter logic [ADDR_W-1:0] XRAM_HI = 16'h0FFF,
  parameter logic [ADDR_W-1:0] CFG_LO  = 16'h2000,
  parameter logic [ADDR_W-1:0] CFG_HI  = 16'h20FF,
  parameter logic [ADDR_W-1:0] BB_LO   = 16'h20C0,
  parameter logic [ADDR_W-1:0] BB_HI   = 16'h20C7
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);

  function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] lo,
                                  input logic [ADDR_W-1:0] hi);
    in_win = (a >= lo) && (a <= hi);
  endfunction

  logic hit_xram, hit_cfg_win, hit_bb;

  assign hit_xram    = in_win(addr, XRAM_LO, XRAM_HI);
  assign hit_cfg_win = in_win(addr, CFG_LO, CFG_HI);
  assign hit_bb      = in_win(addr, BB_LO, BB_HI);

  // battery-backed hole takes priority over the enclosing register window
  always_comb begin
    if (hit_bb)           region = RGN_BBRAM;
    else if (hit_cfg_win) region = RGN_CFG;
    else if (hit_xram)    region = RGN_XRAM;
    else                  region = RGN_NONE;
  end

endmodule

// File: rtl/xdata_addr_gen.sv
module xdata_addr_gen
  import xag_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PAGE_W  = 8,
  parameter int NUM_PTR = 2,
  localparam int ADDR_W = PAGE_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_wr_en,
  input  logic [DATA_W-1:0] sel_wr_data,
  input  logic              page_wr_en,
  input  logic [PAGE_W-1:0] page_wr_data,
  input  logic [1:0]        ptr_op,
  input  logic [ADDR_W-1:0] ptr_load_val,
  input  logic              acc_valid,
  input  logic              acc_paged,
  input  logic              acc_write,
  input  logic [DATA_W-1:0] ri_val,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] xaddr,
  output logic              sel_xram,
  output logic              sel_cfg,
  output logic              sel_bbram,
  output logic              unmapped,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] rd_data
);

  logic [ADDR_W-1:0] cur_ptr;
  region_e           region;
  logic              mapped_acc;   // access hits physical memory
  logic              mapped_rd;

  xag_ptr_bank #(
    .NUM_PTR (NUM_PTR),
    .PTR_W   (ADDR_W),
    .SELREG_W(DATA_W)
  ) u_ptr_bank (
    .clk        (clk),
    .rst        (rst),
    .sel_wr_en  (sel_wr_en),
    .sel_wr_data(sel_wr_data),
    .op         (ptr_op_e'(ptr_op)),
    .load_val   (ptr_load_val),
    .cur_ptr    (cur_ptr)
  );

  xag_addr_mux #(
    .PAGE_W(PAGE_W),
    .LOW_W (DATA_W)
  ) u_addr_mux (
    .clk         (clk),
    .rst         (rst),
    .page_wr_en  (page_wr_en),
    .page_wr_data(page_wr_data),
    .acc_paged   (acc_paged),
    .ri_val      (ri_val),
    .cur_ptr     (cur_ptr),
    .xaddr       (xaddr)
  );

  xag_region_decode #(
    .ADDR_W(ADDR_W)
  ) u_region (
    .addr  (xaddr),
    .region(region)
  );

  assign sel_xram   = acc_valid && (region == RGN_XRAM);
  assign sel_cfg    = acc_valid && (region == RGN_CFG);
  assign sel_bbram  = acc_valid && (region == RGN_BBRAM);
  assign unmapped   = acc_valid && (region == RGN_NONE);
  assign mapped_acc = acc_valid && (region != RGN_NONE);
  assign mapped_rd  = mapped_acc && !acc_write;
  assign mem_we     = mapped_acc && acc_write;
  assign mem_re     = mapped_rd;
  assign rd_data    = mapped_rd ? mem_rdata : '0;

  // R5: exactly one region outcome per access
  p_region_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> $onehot({sel_xram, sel_cfg, sel_bbram, unmapped}))
    else $error("region outcome not one-hot");

  // R5: no outcome without an access
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |-> !(sel_xram || sel_cfg || sel_bbram || unmapped))
    else $error("region flagged while idle");

  // R6: empty space never strobes memory and reads back zero
  p_unmapped_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    unmapped |-> (!mem_we && !mem_re && rd_data == '0))
    else $error("unmapped access reached memory");

  // R1: paged access keeps the register byte in the low half
  p_paged_low_r1: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_paged) |-> xaddr[DATA_W-1:0] == ri_val)
    else $error("paged low byte mismatch");

endmodule

// File: tb/xdata_addr_gen_bench.sv
`timescale 1ns/1ps
module xdata_addr_gen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_wr_en = 1'b0;
  logic [7:0]  sel_wr_data = 8'h00;
  logic        page_wr_en = 1'b0;
  logic [7:0]  page_wr_data = 8'h00;
  logic [1:0]  ptr_op = 2'b00;
  logic [15:0] ptr_load_val = 16'h0000;
  logic        acc_valid = 1'b0;
  logic        acc_paged = 1'b0;
  logic        acc_write = 1'b0;
  logic [7:0]  ri_val = 8'h00;
  logic [7:0]  mem_rdata = 8'h00;
  logic [15:0] xaddr;
  logic        sel_xram, sel_cfg, sel_bbram, unmapped, mem_we, mem_re;
  logic [7:0]  rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xdata_addr_gen u_xdata_addr_gen (
    .clk(clk), .rst(rst), .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data),
    .page_wr_en(page_wr_en), .page_wr_data(page_wr_data), .ptr_op(ptr_op),
    .ptr_load_val(ptr_load_val), .acc_valid(acc_valid), .acc_paged(acc_paged),
    .acc_write(acc_write), .ri_val(ri_val), .mem_rdata(mem_rdata),
    .xaddr(xaddr), .sel_xram(sel_xram), .sel_cfg(sel_cfg), .sel_bbram(sel_bbram),
    .unmapped(unmapped), .mem_we(mem_we), .mem_re(mem_re), .rd_data(rd_data)
  );

  // {page, low byte, region code}; region code 0 empty, 1 shared RAM, 2 config, 3 battery
  localparam logic [17:0] VEC [12] = '{
    {8'h00, 8'h00, 2'd1}, {8'h0F, 8'hFF, 2'd1}, {8'h10, 8'h00, 2'd0},
    {8'h1F, 8'hFF, 2'd0}, {8'h20, 8'h00, 2'd2}, {8'h20, 8'hBF, 2'd2},
    {8'h20, 8'hC0, 2'd3}, {8'h20, 8'hC7, 2'd3}, {8'h20, 8'hC8, 2'd2},
    {8'h20, 8'hFF, 2'd2}, {8'h21, 8'h00, 2'd0}, {8'hFF, 8'hFF, 2'd0}
  };

  // one-hot {battery, config, shared, empty}
  function automatic logic [3:0] region_bits(input logic [1:0] code);
    region_bits = 4'b0001 << code;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic set_sel(input logic [7:0] v);
    sel_wr_en = 1'b1; sel_wr_data = v; tick(); sel_wr_en = 1'b0;
  endtask

  task automatic set_page(input logic [7:0] v);
    page_wr_en = 1'b1; page_wr_data = v; tick(); page_wr_en = 1'b0;
  endtask

  task automatic ptr_do(input logic [1:0] op, input logic [15:0] v);
    ptr_op = op; ptr_load_val = v; tick(); ptr_op = 2'b00;
  endtask

  task automatic ptr_view();
    acc_valid = 1'b1; acc_paged = 1'b0; acc_write = 1'b0; #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;

    // R9: reset state
    ptr_view();
    chk("R9 ptr0 after reset", xaddr, 16'h0000);
    acc_paged = 1'b1; ri_val = 8'h34; #1;
    chk("R9 page after reset", xaddr, 16'h0034);

    // R1 / R5: region table walked via paged access
    foreach (VEC[i]) begin
      set_page(VEC[i][17:10]);
      acc_valid = 1'b1; acc_paged = 1'b1; acc_write = 1'b0;
      ri_val = VEC[i][9:2]; #1;
      chk("R1 paged address", xaddr, {VEC[i][17:10], VEC[i][9:2]});
      chk("R5 region decode", {sel_bbram, sel_cfg, sel_xram, unmapped},
          region_bits(VEC[i][1:0]));
    end
    acc_valid = 1'b0; #1;
    chk("R5 idle no region", {sel_bbram, sel_cfg, sel_xram, unmapped}, 4'b0000);

    // R7 / R2: load pointer 0
    ptr_do(2'b01, 16'h1234);
    ptr_view();
    chk("R2 R7 ptr0 load", xaddr, 16'h1234);

    // R3: upper select bits ignored
    set_sel(8'hFE);
    ptr_view();
    chk("R3 sel upper bits ignored", xaddr, 16'h1234);

    // R3 / R4: switch to pointer 1, which is still clear
    set_sel(8'h01);
    ptr_view();
    chk("R3 R9 ptr1 selected and clear", xaddr, 16'h0000);
    ptr_do(2'b01, 16'h20C3);
    ptr_view();
    chk("R2 ptr1 load", xaddr, 16'h20C3);
    chk("R5 ptr1 battery region", sel_bbram, 1'b1);

    // R4: ptr0 untouched by ptr1 load and select changes
    set_sel(8'h00);
    ptr_view();
    chk("R4 ptr0 kept", xaddr, 16'h1234);
    ptr_do(2'b10, 16'h0000);
    ptr_view();
    chk("R7 ptr0 increment", xaddr, 16'h1235);
    ptr_do(2'b11, 16'hBEEF);
    ptr_view();
    chk("R7 reserved op holds", xaddr, 16'h1235);
    set_sel(8'h01);
    ptr_view();
    chk("R4 ptr1 kept across ptr0 inc", xaddr, 16'h20C3);

    // R7: wrap
    ptr_do(2'b01, 16'hFFFF);
    ptr_do(2'b10, 16'h0000);
    ptr_view();
    chk("R7 wrap to zero", xaddr, 16'h0000);

    // R8: access and increment in the same cycle
    set_sel(8'h00);
    ptr_view();
    ptr_op = 2'b10; #1;
    chk("R8 access sees pre-inc ptr", xaddr, 16'h1235);
    tick(); ptr_op = 2'b00; #1;
    chk("R8 ptr stepped after edge", xaddr, 16'h1236);

    // R8: access and select write in the same cycle
    sel_wr_en = 1'b1; sel_wr_data = 8'h01; #1;
    chk("R8 access sees old select", xaddr, 16'h1236);
    tick(); sel_wr_en = 1'b0; #1;
    chk("R8 new select after edge", xaddr, 16'h0000);

    // R8: page write during paged access
    acc_paged = 1'b1; ri_val = 8'h10;
    page_wr_en = 1'b1; page_wr_data = 8'h05; #1;
    chk("R8 paged sees old page", xaddr, 16'hFF10);
    tick(); page_wr_en = 1'b0; #1;
    chk("R8 page updated after edge", xaddr, 16'h0510);

    // R6: mapped vs unmapped traffic
    mem_rdata = 8'hAA; acc_write = 1'b0; #1;
    chk("R6 mapped read data", rd_data, 8'hAA);
    chk("R6 mapped read strobe", mem_re, 1'b1);
    acc_write = 1'b1; #1;
    chk("R6 mapped write strobe", mem_we, 1'b1);
    set_page(8'h30);
    acc_write = 1'b0; #1;
    chk("R6 unmapped flag", unmapped, 1'b1);
    chk("R6 unmapped read zero", rd_data, 8'h00);
    chk("R6 unmapped no read strobe", mem_re, 1'b0);
    acc_write = 1'b1; #1;
    chk("R6 unmapped write ignored", mem_we, 1'b0);
    acc_write = 1'b0;

    // R9: reset mid-run
    rst = 1'b1; tick(); rst = 1'b0;
    ptr_view();
    chk("R9 ptr0 cleared", xaddr, 16'h0000);
    set_sel(8'h01);
    ptr_view();
    chk("R9 ptr1 cleared", xaddr, 16'h0000);
    acc_paged = 1'b1; ri_val = 8'h77; #1;
    chk("R9 page cleared", xaddr, 16'h0077);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule